// File: doc/BRIEF.md
# Consecutive-Ones Run Detector (Moore and Mealy)

This block watches a single serial bit `x` that is sampled on every rising edge of `clk`. It signals when `x` has been 1 on at least three consecutive sampling edges. Two independent state machines read the same input and each drives its own output, so that the two output styles can be compared directly.

The state-decoded machine (`z_moore`) has four states and decodes its output from the state register alone. Its output goes high in the cycle after the edge that samples the third 1. The input-decoded machine (`z_mealy`) has three states and combines its state with the live input. Its output goes high during the cycle in which the third 1 is presented, before that 1 is sampled. A synchronous active-low reset puts both machines in their idle state. This means neither output is undefined before the first input.

Top module: `ones_run_detector`

## Requirements
- R1: While `rst_n` is 0 on a rising edge, both machines go to the idle state (code 2'b00) whatever `x` is. In the cycle after reset, `z_moore` is 0, and `z_mealy` is 0 for either value of `x`.
- R2: Sampling `x`=0 on a rising edge returns the state-decoded machine to idle, so `z_moore` is 0 in the next cycle.
- R3: With state codes idle=00, one=01, two=10, run=11, each sampled 1 moves the state-decoded machine one step forward. `z_moore` is 1 in the cycle after the third consecutive sampled 1, and never earlier.
- R4: Once in the run state, further sampled 1s keep the state-decoded machine there, so `z_moore` stays 1.
- R5: `z_moore` depends only on the state. Changing `x` between clock edges does not change it.
- R6: `z_mealy` is 1 exactly when the three-state machine is in its third state (two 1s sampled in a row) and `x` is 1 now. It is 0 for every other pair of state and input.
- R7: Sampling `x`=0 returns the three-state machine to idle, so `z_mealy` is 0 in the next cycle whatever `x` is.
- R8: With `x`=1 sampled in the third state, the three-state machine stays there. `z_mealy` is then 1 for every further cycle in which `x` is 1.
- R9: For the input sequence 0,1,1,1,0,0,1,1,1,1,0,0 applied from idle, the state-decoded machine passes through idle, one, two, run, idle, idle, one, two, run, run, idle, idle. `z_moore` is therefore 1 after the 4th, 9th and 10th edges only.
- R10: A reset asserted in the middle of a run returns both outputs to their idle behaviour. Counting starts again from zero after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x | input | 1 | Serial input bit |
| z_moore | output | 1 | Run flag decoded from state only, one cycle after the third 1 |
| z_mealy | output | 1 | Run flag decoded from state and input, during the third 1 |

## Verification
The bound checker watches several things on every cycle. Reset clears the state-decoded output. A sampled 0 clears both outputs in the next cycle. The input-decoded output is always followed by the state-decoded output one cycle later. A high `z_moore` is always preceded by two sampled 1s. `z_mealy` is never high while `x` is low, and it stays high while 1s continue. Some behaviour needs the bench's scenarios instead. These are the exact cycle in which each output first rises, the golden state trace, the insensitivity of `z_moore` to changes of `x` between edges, and a full sweep of every 8-bit input pattern against a saturating run counter.

// File: rtl/ones_det_pkg.sv
// Package: shared state encoding for both run-detector machines.
// Assumes a 2-bit binary code. The three-state machine uses only the
// first three codes.
package ones_det_pkg;
    localparam int unsigned STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_RUN  = 2'b11
    } run_state_e;
endpackage

// File: rtl/ones_moore_fsm.sv
// Four-state run detector whose output is decoded from the state only.
// Assumes x is stable around the rising edge of clk. The reset is
// synchronous and active low.
module ones_moore_fsm
    import ones_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic z
);
    run_state_e state_q;
    run_state_e state_d;

    // Next-state: a 0 goes back to idle, a 1 climbs and saturates in run.
    always_comb begin
        state_d = ST_IDLE;
        if (x) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ONE;
                ST_ONE:  state_d = ST_TWO;
                ST_TWO:  state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the state alone.
    always_comb z = (state_q == ST_RUN);
endmodule

// File: rtl/ones_mealy_fsm.sv
// Three-state run detector whose output is decoded from state and input.
// Assumes x is stable around the rising edge of clk. Code 2'b11 is never
// entered and is treated as idle if it ever appears.
module ones_mealy_fsm
    import ones_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic z
);
    run_state_e state_q;
    run_state_e state_d;

    // Next-state: a 0 goes back to idle, a 1 climbs and saturates in state two.
    always_comb begin
        state_d = ST_IDLE;
        if (x) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ONE;
                ST_ONE:  state_d = ST_TWO;
                ST_TWO:  state_d = ST_TWO;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the present state combined with the live input.
    always_comb z = x && (state_q == ST_TWO);
endmodule

// File: rtl/ones_run_detector.sv
// Top: runs the state-decoded and the input-decoded detectors side by side
// on the same serial input. Both machines share clock and reset.
module ones_run_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic z_moore,
    output logic z_mealy
);
    ones_moore_fsm u_moore (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (x),
        .z     (z_moore)
    );

    ones_mealy_fsm u_mealy (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (x),
        .z     (z_mealy)
    );
endmodule

// File: rtl/ones_run_detector_chk.sv
// Checker: cycle-by-cycle properties on the detector's ports.
// It is attached to the top module by the bind statement at the end of this file.
module ones_run_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic x,
    input logic z_moore,
    input logic z_mealy
);
    // Reset clears the state-decoded output on the next cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !z_moore);

    // A sampled 0 clears both outputs on the next cycle (R2, R7).
    assert_zero_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !x |=> (!z_moore && !z_mealy));

    // The input-decoded flag is followed by the state-decoded flag one cycle later.
    assert_moore_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        z_mealy |=> z_moore);

    // The state-decoded flag needs the two previous samples to be 1.
    assert_moore_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        z_moore |-> ($past(x, 1) && $past(x, 2)));

    // The input-decoded flag is never high while the input is low.
    assert_mealy_needs_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        z_mealy |-> x);

    // The input-decoded flag stays high while 1s continue.
    assert_mealy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        z_mealy ##1 x |-> z_mealy);
endmodule

bind ones_run_detector ones_run_detector_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x       (x),
    .z_moore (z_moore),
    .z_mealy (z_mealy)
);

// File: tb/ones_run_detector_bench.sv
`timescale 1ns/100ps
module ones_run_detector_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x = 1'b0;
    logic z_moore;
    logic z_mealy;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   run = 0;   // reference count of consecutive sampled 1s, saturating at 3
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    ones_run_detector u_ones_run_detector (
        .clk     (clk),
        .rst_n   (rst_n),
        .x       (x),
        .z_moore (z_moore),
        .z_mealy (z_mealy)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Called at a falling edge: applies v, checks both outputs before the
    // rising edge, then advances the reference model and returns at the next falling edge.
    task automatic step(input logic v, input string rq_moore, input string rq_mealy);
        x = v;
        #1;
        check(z_moore, (run == 3), rq_moore);
        check(z_mealy, (v && run >= 2), rq_mealy);
        @(posedge clk);
        run = v ? ((run < 3) ? run + 1 : 3) : 0;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic xv);
        rst_n = 1'b0;
        x = xv;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        run = 0;
    endtask

    initial begin
        int trace [12] = '{0, 1, 2, 3, 0, 0, 1, 2, 3, 3, 0, 0};
        logic seq [12] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                           1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
        @(negedge clk);
        // R1: reset held with x=1, then the outputs start from idle.
        do_reset(1'b1);
        #1;
        check(z_moore, 1'b0, "R1 moore after reset");
        check(z_mealy, 1'b0, "R1 mealy after reset with x=1");
        @(negedge clk);
        do_reset(1'b0);

        // R9: golden trace, checking z_moore after each edge.
        for (int i = 0; i < 12; i++) begin
            x = seq[i];
            @(posedge clk);
            @(negedge clk);
            #1;
            check(z_moore, (trace[i] == 3), "R9 golden trace");
        end

        // R5: z_moore ignores x changes between edges.
        @(negedge clk);
        do_reset(1'b0);
        step(1'b1, "R3", "R6");
        step(1'b1, "R3", "R6");
        step(1'b1, "R3", "R6");
        x = 1'b1;
        #1;
        check(z_moore, 1'b1, "R5 run state with x=1");
        x = 1'b0;
        #1;
        check(z_moore, 1'b1, "R5 run state after x fell mid-cycle");
        check(z_mealy, 1'b0, "R6 mealy low with x=0");
        x = 1'b1;
        #1;
        check(z_mealy, 1'b1, "R6 mealy high in state two with x=1");
        @(posedge clk);
        run = 3;
        @(negedge clk);

        // R10: reset in mid-run, then count again.
        do_reset(1'b1);
        step(1'b1, "R10 moore after mid-run reset", "R10 mealy after mid-run reset");
        step(1'b1, "R10 moore second 1", "R10 mealy second 1");
        step(1'b1, "R10 moore third 1", "R10 mealy third 1");
        step(1'b0, "R10 moore run", "R10 mealy on 0");

        // Sweep of all 8-bit patterns from idle (R2 R3 R4 R6 R7 R8).
        for (int p = 0; p < 256; p++) begin
            do_reset(1'b0);
            for (int b = 0; b < 8; b++)
                step(p[b], "R2 R3 R4 moore sweep", "R6 R7 R8 mealy sweep");
            step(1'b0, "R4 R2 moore sweep tail", "R7 mealy sweep tail");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule